// File: doc/BRIEF.md
# Four-Channel Square Wave Note Player

This block turns a small bitmap of cell data into sound. The bitmap sits in a single-bit-wide RAM whose address is split into a column number (upper bits) and a cell number from 0 to 15 (lower four bits). Before playback the RAM address bus belongs to a loader outside the block. Once the play button is seen, the player takes the address bus and keeps it until reset. It then treats each column as one time slot and walks the columns in ascending order, wrapping back to column 0 after the last one.

Each column holds 16 cells, and each cell number stands for one note. In every slot the four live cells with the lowest numbers go to the four tone channels, lowest first. Each channel is a counter that flips a square-wave pin every half-period. The half-period comes from the note number through a linear table in clock cycles. The cells of the next column are fetched one per clock into a register near the start of each slot, and the channel assignments change only at slot boundaries.

Top module: `sq_note_player`

## Requirements
- R1: While in reset and until play is pressed, every `tone_out` bit is 0 and `ram_addr` equals `ld_addr`.
- R2: From the clock edge that samples `play_btn` high onward, `ram_addr` is driven by the player as {column, cell}, with the cell number in bits [3:0] and the column above it. `ld_addr` and later presses of `play_btn` have no effect.
- R3: At the edge that samples play, the player starts reading column 0 at cell 0, one cell address per clock in ascending order. The first slot begins 18 clocks after that edge.
- R4: Every slot lasts exactly SLOT_CLKS clocks. Slots play columns 0, 1, 2 and so on, and wrap to column 0 after column 2**COL_W-1.
- R5: In each slot, channel 0 takes the lowest-numbered live cell (a cell whose RAM bit is 1), channel 1 the next, and so on up to channel 3.
- R6: Live cells beyond the fourth in a column produce no sound on any channel.
- R7: A channel assigned cell n has a half-period of HALF_BASE - n*HALF_STEP clocks.
- R8: At the start of each slot, every assigned channel begins low. Its output then flips every half-period until the slot ends.
- R9: A channel with no assigned cell in a slot holds its output at 0 for the whole slot.
- R10: A column's cells are sampled during the first 18 clocks of the slot before it plays. A RAM write to that column after this window is heard only on the column's next pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| play_btn | input | 1 | Play request; the first sampled high starts playback |
| ld_addr | input | COL_W+4 | Loader address, forwarded to the RAM before play |
| ram_addr | output | COL_W+4 | Address to the small RAM port |
| ram_rdata | input | 1 | RAM read data, one clock after the address |
| tone_out | output | 4 | Square-wave outputs, one per channel |

## Verification
The hardest case to reach is R10. It needs a RAM write that lands after a column has been sampled but before that column plays, and a later check that the write is heard only one full lap later. The bench's RAM model clears column 1 fifty clocks into the first slot. It then expects the old notes in slot 1 and silence when column 1 comes round again in slot 5. The column patterns also cover more than four live cells, no live cells, all cells live, and the highest cell number, which has the shortest half-period.

// File: rtl/np_pkg.sv
// Package: shared constants and types for the note player.
// Assumes a fixed 16 cells per column and four tone channels.
package np_pkg;
    localparam int CELLS = 16;
    localparam int CHANS = 4;
    localparam int CELL_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PLAY = 2'd2
    } np_state_e;
endpackage

// File: rtl/np_col_fetch.sv
// Module: column sequencer. It waits for play, then reads 16 cells of a column
// one per clock into a register, and times the slots of SLOT_CLKS clocks.
// Assumes RAM read latency of one clock and SLOT_CLKS >= 18.
module np_col_fetch
    import np_pkg::*;
#(
    parameter int COL_W     = 4,
    parameter int SLOT_CLKS = 7_500_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    play_btn,
    input  logic                    rd_data,
    output logic                    playing,
    output logic                    slot_start,
    output logic [CELLS-1:0]        cells,
    output logic [COL_W+CELL_W-1:0] rd_addr
);
    localparam int SLOT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    np_state_e           state;
    logic [COL_W-1:0]    fcol;
    logic [CELL_W:0]     fidx;
    logic                cap_v;
    logic [CELL_W-1:0]   cap_i;
    logic [SLOT_W-1:0]   slot_cnt;

    // Purpose: flag the edge at which a new slot starts.
    always_comb begin
        slot_start = ((state == ST_FILL) && (fidx == 5'(CELLS)) && !cap_v) ||
                     ((state == ST_PLAY) && (slot_cnt == SLOT_W'(SLOT_CLKS - 1)));
    end

    assign playing = (state != ST_IDLE);
    assign rd_addr = {fcol, fidx[CELL_W-1:0]};

    // Purpose: issue cell reads, capture returning data and step slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fcol     <= '0;
            fidx     <= 5'(CELLS);
            cap_v    <= 1'b0;
            cap_i    <= '0;
            slot_cnt <= '0;
            cells    <= '0;
        end else begin
            cap_v <= 1'b0;
            if (state != ST_IDLE && fidx < 5'(CELLS)) begin
                fidx  <= fidx + 5'd1;
                cap_v <= 1'b1;
                cap_i <= fidx[CELL_W-1:0];
            end
            if (cap_v) begin
                cells[cap_i] <= rd_data;
            end
            case (state)
                ST_IDLE: begin
                    if (play_btn) begin
                        state <= ST_FILL;
                        fidx  <= '0;
                        fcol  <= '0;
                    end
                end
                ST_FILL: begin
                    if (slot_start) begin
                        state    <= ST_PLAY;
                        slot_cnt <= '0;
                        fcol     <= fcol + 1'b1;
                        fidx     <= '0;
                    end
                end
                default: begin
                    if (slot_start) begin
                        slot_cnt <= '0;
                        fcol     <= fcol + 1'b1;
                        fidx     <= '0;
                    end else begin
                        slot_cnt <= slot_cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/np_note_alloc.sv
// Module: picks the four lowest-numbered live cells of a column, in ascending
// order, for channels 0..3. Purely combinational; extra live cells are dropped.
module np_note_alloc
    import np_pkg::*;
(
    input  logic [CELLS-1:0]             cells,
    output logic [CHANS-1:0]             valid,
    output logic [CHANS-1:0][CELL_W-1:0] note
);
    logic [2:0] k;

    // Purpose: scan cells upward and fill channels in order.
    always_comb begin
        valid = '0;
        note  = '0;
        k     = '0;
        for (int i = 0; i < CELLS; i++) begin
            if (cells[i] && k < 3'(CHANS)) begin
                valid[k[1:0]] = 1'b1;
                note[k[1:0]]  = CELL_W'(i);
                k             = k + 3'd1;
            end
        end
    end
endmodule

// File: rtl/np_tone_gen.sv
// Module: one square-wave channel. It restarts low at each slot start and
// flips every `half` clocks while enabled. Assumes half >= 1.
module np_tone_gen #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             enable,
    input  logic [CNT_W-1:0] half,
    output logic             wave
);
    logic [CNT_W-1:0] cnt;

    // Purpose: count clocks and flip the output at the half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !enable) begin
            cnt  <= '0;
            wave <= 1'b0;
        end else if (cnt == half - 1'b1) begin
            cnt  <= '0;
            wave <= ~wave;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sq_note_player.sv
// Module: top of the four-channel note player. It owns the RAM address mux,
// latches channel assignments at slot starts and drives four tone channels.
// Assumes a 1-clock synchronous RAM read and HALF_BASE > 15*HALF_STEP.
module sq_note_player
    import np_pkg::*;
#(
    parameter int COL_W     = 4,
    parameter int SLOT_CLKS = 7_500_000,
    parameter int HALF_BASE = 170_000,
    parameter int HALF_STEP = 8_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    play_btn,
    input  logic [COL_W+3:0]        ld_addr,
    output logic [COL_W+3:0]        ram_addr,
    input  logic                    ram_rdata,
    output logic [CHANS-1:0]        tone_out
);
    localparam int CNT_W = $clog2(HALF_BASE + 1);

    logic                             playing;
    logic                             slot_start;
    logic [CELLS-1:0]                 cells;
    logic [COL_W+3:0]                 rd_addr;
    logic [CHANS-1:0]                 nxt_valid;
    logic [CHANS-1:0][CELL_W-1:0]     nxt_note;
    logic [CHANS-1:0]                 ch_valid;
    logic [CHANS-1:0][CELL_W-1:0]     ch_note;

    np_col_fetch #(
        .COL_W     (COL_W),
        .SLOT_CLKS (SLOT_CLKS)
    ) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .play_btn   (play_btn),
        .rd_data    (ram_rdata),
        .playing    (playing),
        .slot_start (slot_start),
        .cells      (cells),
        .rd_addr    (rd_addr)
    );

    np_note_alloc u_alloc (
        .cells (cells),
        .valid (nxt_valid),
        .note  (nxt_note)
    );

    // Purpose: hand the RAM address bus to the player once playing.
    always_comb begin
        case (playing)
            1'b1:    ram_addr = rd_addr;
            default: ram_addr = ld_addr;
        endcase
    end

    // Purpose: hold channel assignments for the length of a slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_valid <= '0;
            ch_note  <= '0;
        end else if (slot_start) begin
            ch_valid <= nxt_valid;
            ch_note  <= nxt_note;
        end
    end

    for (genvar g = 0; g < CHANS; g++) begin : g_chan
        logic [CNT_W-1:0] half;

        // Purpose: map the cell number to its half-period in clocks.
        always_comb begin
            half = CNT_W'(HALF_BASE) - CNT_W'(ch_note[g]) * CNT_W'(HALF_STEP);
        end

        np_tone_gen #(
            .CNT_W (CNT_W)
        ) u_tone (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (slot_start),
            .enable  (ch_valid[g]),
            .half    (half),
            .wave    (tone_out[g])
        );
    end
endmodule

// File: rtl/np_checker.sv
// Module: property checker for the note player, bound to the top module.
module np_checker
    import np_pkg::*;
#(
    parameter int SLOT_CLKS = 7_500_000,
    parameter int HALF_BASE = 170_000,
    parameter int HALF_STEP = 8_000
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         slot_start,
    input logic                         playing,
    input logic [CHANS-1:0]             ch_valid,
    input logic [CHANS-1:0][CELL_W-1:0] ch_note,
    input logic [CHANS-1:0]             tone_out
);
    logic [31:0] gap;
    logic        seen;

    initial begin
        p_params_r4: assert (SLOT_CLKS >= 18 && HALF_BASE > 15 * HALF_STEP)
            else $error("parameter limits broken");
    end

    // Purpose: measure the clocks between slot starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap  <= '0;
            seen <= 1'b0;
        end else if (slot_start) begin
            gap  <= '0;
            seen <= 1'b1;
        end else if (gap != 32'hFFFF_FFFF) begin
            gap <= gap + 1;
        end
    end

    p_slot_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && seen) |-> (gap == 32'(SLOT_CLKS - 1)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> ($stable(ch_valid) && $stable(ch_note)));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !playing |-> (tone_out == '0));

    for (genvar g = 0; g < CHANS; g++) begin : g_ch
        p_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_valid[g] |-> !tone_out[g]);
        p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(tone_out[g]) |-> (ch_valid[g] && !$past(slot_start)));
    end

    for (genvar g = 0; g < CHANS - 1; g++) begin : g_pair
        p_pack_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_valid[g+1] |-> ch_valid[g]);
        p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_valid[g+1] |-> (ch_note[g] < ch_note[g+1]));
    end
endmodule

bind sq_note_player np_checker #(
    .SLOT_CLKS (SLOT_CLKS),
    .HALF_BASE (HALF_BASE),
    .HALF_STEP (HALF_STEP)
) u_np_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_start (slot_start),
    .playing    (playing),
    .ch_valid   (ch_valid),
    .ch_note    (ch_note),
    .tone_out   (tone_out)
);

// File: tb/sq_note_player_test.sv
module sq_note_player_test;
    localparam int COL_W = 2;
    localparam int SLOT = 120;
    localparam int HB   = 20;
    localparam int HS   = 1;
    localparam int AW   = COL_W + 4;

    typedef struct {
        int         col;
        logic [3:0] v;
        int         n [4];
    } slot_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          play_btn = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [AW-1:0] ram_addr;
    logic          ram_rdata = 1'b0;
    logic [3:0]    tone_out;
    logic          mem [64];

    int     n_checks = 0;
    int     n_fail = 0;
    slot_t  exp_q [$];

    sq_note_player #(
        .COL_W     (COL_W),
        .SLOT_CLKS (SLOT),
        .HALF_BASE (HB),
        .HALF_STEP (HS)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .play_btn  (play_btn),
        .ld_addr   (ld_addr),
        .ram_addr  (ram_addr),
        .ram_rdata (ram_rdata),
        .tone_out  (tone_out)
    );

    always #2 clk = ~clk;

    // RAM model with a one-clock read
    always @(posedge clk) ram_rdata <= mem[ram_addr];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Driver: compute the expected channel plan of one slot and queue it
    task automatic push_slot(input int col, input logic [15:0] cells);
        slot_t s;
        int k = 0;
        s.col = col;
        s.v = '0;
        for (int i = 0; i < 4; i++) s.n[i] = 0;
        for (int i = 0; i < 16; i++) begin
            if (cells[i] && k < 4) begin
                s.v[k] = 1'b1;
                s.n[k] = i;
                k++;
            end
        end
        exp_q.push_back(s);
    endtask

    function automatic logic wave_at(input int note, input int m);
        int h = HB - note * HS;
        return ((m / h) % 2) == 1;
    endfunction

    // Monitor: pop one slot plan and compare all four channels every clock
    task automatic run_monitor(input int nslots);
        for (int s = 0; s < nslots; s++) begin
            slot_t e;
            int bad [4];
            int act [4];
            int ex [4];
            e = exp_q.pop_front();
            for (int c = 0; c < 4; c++) bad[c] = 0;
            for (int m = 0; m < SLOT; m++) begin
                @(negedge clk);
                for (int c = 0; c < 4; c++) begin
                    logic want = e.v[c] ? wave_at(e.n[c], m) : 1'b0;
                    if (tone_out[c] !== want && bad[c] == 0) begin
                        bad[c] = 1;
                        act[c] = int'(tone_out[c]);
                        ex[c] = int'(want);
                    end
                end
                @(posedge clk);
            end
            for (int c = 0; c < 4; c++) begin
                string tag;
                if (e.v[c]) tag = $sformatf("R3 R4 R5 R6 R7 R8 R10 slot %0d col %0d ch %0d", s, e.col, c);
                else tag = $sformatf("R9 R4 R10 slot %0d col %0d ch %0d", s, e.col, c);
                check(bad[c] == 0, tag, act[c], ex[c]);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [15:0] c0, c1, c2, c3;
        c0 = 16'h8088;
        c1 = 16'h8227;
        c2 = 16'h0000;
        c3 = 16'hFFFF;
        for (int i = 0; i < 16; i++) begin
            mem[i]      = c0[i];
            mem[16 + i] = c1[i];
            mem[32 + i] = c2[i];
            mem[48 + i] = c3[i];
        end

        repeat (3) @(negedge clk);
        ld_addr = 6'h15;
        #1;
        check(tone_out == 4'b0, "R1 reset tones", int'(tone_out), 0);
        check(ram_addr == 6'h15, "R1 reset addr", int'(ram_addr), 'h15);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        ld_addr = 6'h2C;
        #1;
        check(ram_addr == 6'h2C, "R1 idle addr", int'(ram_addr), 'h2C);
        check(tone_out == 4'b0, "R1 idle tones", int'(tone_out), 0);

        push_slot(0, c0);
        push_slot(1, c1);
        push_slot(2, c2);
        push_slot(3, c3);
        push_slot(0, c0);
        push_slot(1, 16'h0000);

        @(negedge clk);
        play_btn = 1'b1;
        ld_addr = 6'h3B;
        @(posedge clk);
        fork
            begin
                @(negedge clk);
                play_btn = 1'b0;
                ld_addr = 6'h11;
                #1;
                check(ram_addr == 6'h00, "R2 R3 first addr", int'(ram_addr), 0);
                repeat (5) @(posedge clk);
                @(negedge clk);
                play_btn = 1'b1;
                #1;
                check(ram_addr == 6'h05, "R2 R3 fifth addr", int'(ram_addr), 5);
                @(negedge clk);
                play_btn = 1'b0;
            end
            begin
                repeat (18) @(posedge clk);
                run_monitor(6);
            end
            begin
                repeat (18 + 50) @(posedge clk);
                @(negedge clk);
                for (int i = 0; i < 16; i++) mem[16 + i] = 1'b0;
            end
        join

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule